// File: doc/BRIEF.md
# RAM Sweep Tester

This block checks every word of an attached synchronous single-port RAM. After a start pulse it walks the addresses from zero up to the top address. At each address it reads the word that is already there and keeps a copy. It then writes a first test pattern, reads it back and compares. It writes the bitwise complement of that pattern, reads it back and compares again. Last, it writes a final value into the word.

A mode input is sampled with the start pulse, and it chooses the final value. In preserve mode the tester writes back the saved word, so the RAM keeps its contents across the run. In clear mode it writes zero, so a run made at power-up leaves the whole RAM zero-filled.

When a compare fails, the tester still writes the final value to the current word. It then stops and raises fail together with done. The addresses above the failing one are not touched. A host maps a set fail flag to its processor-fault indication.

Top module: `ram_sweep_tester`

## Requirements
- R1: After an accepted start, addresses 0 up to 2^ADDR_W-1 are visited in ascending order. Each address takes six cycles: read, write pattern, read, write complement, read, write final value.
- R2: The first pattern written to each address is PAT_A (default 8'h55). The second is its complement (default 8'hAA).
- R3: Read data is sampled one clock after its address is presented, and the address holds steady for the read and the following write.
- R4: In clear mode (mode input 0 at start), the final value written to every visited address is zero.
- R5: In preserve mode (mode input 1 at start), the final value written to every visited address is the word read from it at the beginning of its step.
- R6: A compare mismatch at an address makes the tester finish that address, then stop with done=1 and fail=1. No write is made after done rises, and no higher address is written.
- R7: A run with no mismatch ends with done=1 and fail=0. Done is first seen 6*2^ADDR_W+1 cycles after the start edge, counting the cycle in which start is sampled.
- R8: While reset is held and right after it is released, done, fail and the write enable are 0.
- R9: Start is ignored while a run is in progress. Start given when idle or done begins a new run from address 0 and clears done and fail. Without start, done stays high.
- R10: The mode is captured at the start edge. Changes on the mode input during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a run when idle or done |
| keep_i | input | 1 | Mode at start: 1 preserve contents, 0 clear to zero |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, valid one clock after the address |
| done_o | output | 1 | Run finished; held until the next start |
| fail_o | output | 1 | Run finished on a compare mismatch |

## Verification
Two things happen in the same cycle. The comparison of the read-back word is one. The write of the next value to the same address is the other: the complement after the first compare, and the final value after the second. A compare failure therefore lands in a cycle that is already writing.

The bench provokes this with a RAM model that has a stuck bit at one address. One fault breaks the first pattern at address 0, and another breaks the complement at address 5. A scoreboard queue holds the expected writes, and each run is judged on three things: the complete ordered list of writes, including the final write at the failing address; the stop cycle; and the untouched words above the failing address.

// File: rtl/ram_tester_pkg.sv
package ram_tester_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD0  = 3'd1,
    ST_WR1  = 3'd2,
    ST_RD1  = 3'd3,
    ST_CK1  = 3'd4,
    ST_RD2  = 3'd5,
    ST_CK2  = 3'd6,
    ST_DONE = 3'd7
  } tstate_t;
endpackage

// File: rtl/ram_tester_fsm.sv
module ram_tester_fsm
  import ram_tester_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_acc_i,
  input  logic    finish_i,
  output tstate_t state_o
);
  tstate_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start_acc_i) st_d = ST_RD0;
      ST_RD0:  st_d = ST_WR1;
      ST_WR1:  st_d = ST_RD1;
      ST_RD1:  st_d = ST_CK1;
      ST_CK1:  st_d = ST_RD2;
      ST_RD2:  st_d = ST_CK2;
      ST_CK2:  st_d = finish_i ? ST_DONE : ST_RD0;
      ST_DONE: if (start_acc_i) st_d = ST_RD0;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/ram_tester_addr.sv
module ram_tester_addr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  assign addr_en = clr_i | inc_i;

  always_comb begin
    if (clr_i) addr_d = '0;
    else       addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == TOP);
endmodule

// File: rtl/ram_tester_dp.sv
module ram_tester_dp
  import ram_tester_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] PAT_A  = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_t           state_i,
  input  logic              start_acc_i,
  input  logic              keep_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              mismatch_o,
  output logic              err_o,
  output logic              keep_o
);
  localparam logic [DATA_W-1:0] PAT_B = ~PAT_A;

  logic [DATA_W-1:0] save_q;
  logic              save_en;
  logic              keep_q;
  logic              err_q, err_d, err_en;

  assign save_en = (state_i == ST_WR1);

  always_comb begin
    mismatch_o = 1'b0;
    if (state_i == ST_CK1) mismatch_o = (rdata_i != PAT_A);
    if (state_i == ST_CK2) mismatch_o = (rdata_i != PAT_B);
  end

  assign err_en = start_acc_i | mismatch_o;
  assign err_d  = ~start_acc_i;

  always_comb begin
    we_o    = 1'b0;
    wdata_o = '0;
    case (state_i)
      ST_WR1: begin we_o = 1'b1; wdata_o = PAT_A; end
      ST_CK1: begin we_o = 1'b1; wdata_o = PAT_B; end
      ST_CK2: begin we_o = 1'b1; wdata_o = keep_q ? save_q : '0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_q <= '0;
      keep_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (save_en)     save_q <= rdata_i;
      if (start_acc_i) keep_q <= keep_i;
      if (err_en)      err_q  <= err_d;
    end
  end

  assign err_o  = err_q;
  assign keep_o = keep_q;
endmodule

// File: rtl/ram_sweep_tester.sv
module ram_sweep_tester
  import ram_tester_pkg::*;
#(
  parameter int                ADDR_W = 4,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] PAT_A  = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              keep_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              fail_o
);
  logic    rs_meta_q, rs_q;
  tstate_t st;
  logic    start_acc, finish, last, mismatch, err_q, keep_q, inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  assign start_acc = start_i & ((st == ST_IDLE) | (st == ST_DONE));
  assign finish    = err_q | mismatch | last;
  assign inc       = (st == ST_CK2) & ~finish;

  ram_tester_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rs_q),
    .start_acc_i (start_acc),
    .finish_i    (finish),
    .state_o     (st)
  );

  ram_tester_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rs_q),
    .clr_i  (start_acc),
    .inc_i  (inc),
    .addr_o (mem_addr_o),
    .last_o (last)
  );

  ram_tester_dp #(.DATA_W(DATA_W), .PAT_A(PAT_A)) u_dp (
    .clk         (clk),
    .rst_n       (rs_q),
    .state_i     (st),
    .start_acc_i (start_acc),
    .keep_i      (keep_i),
    .rdata_i     (mem_rdata_i),
    .we_o        (mem_we_o),
    .wdata_o     (mem_wdata_o),
    .mismatch_o  (mismatch),
    .err_o       (err_q),
    .keep_o      (keep_q)
  );

  assign done_o = (st == ST_DONE);
  assign fail_o = done_o & err_q;
endmodule

// File: rtl/ram_tester_chk.sv
module ram_tester_chk
  import ram_tester_pkg::*;
#(
  parameter int                ADDR_W = 4,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] PAT_A  = 8'h55
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              done_o,
  input logic              fail_o,
  input tstate_t           st,
  input logic              keep_q
);
  localparam logic [DATA_W-1:0] PAT_B = ~PAT_A;

  assert_fail_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> done_o);

  assert_no_write_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_we_o);

  assert_addr_walk_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr_o != $past(mem_addr_o)) |->
      ((mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)) || (mem_addr_o == '0)));

  assert_second_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CK1) |-> (mem_we_o && mem_wdata_o == PAT_B));

  assert_clear_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CK2 && !keep_q) |-> (mem_we_o && mem_wdata_o == '0));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD0) |=> $stable(mem_addr_o));

  assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && st != ST_DONE && st != ST_RD0) |-> $stable(keep_q));
endmodule

bind ram_sweep_tester ram_tester_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_A(PAT_A)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .mem_addr_o  (mem_addr_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .st          (st),
  .keep_q      (keep_q)
);

// File: tb/sim_ram_sweep_tester.sv
module sim_ram_sweep_tester;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk, rst_n, start_i, keep_i;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          done_o, fail_o;

  logic [DW-1:0] mem [N];
  logic [DW-1:0] shadow [N];
  logic          tb_we;
  logic [AW-1:0] tb_addr;
  logic [DW-1:0] tb_data;
  logic          f_on;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_mask, f_val;

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
  wr_t exp_q[$];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  ram_sweep_tester #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .keep_i(keep_i),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .done_o(done_o), .fail_o(fail_o));

  initial clk = 0;
  always #5 clk = ~clk;

  // RAM model with optional stuck bits at one address
  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr];
    if (mem_we) begin
      if (f_on && mem_addr == f_addr) mem[mem_addr] <= (mem_wdata & ~f_mask) | (f_val & f_mask);
      else                            mem[mem_addr] <= mem_wdata;
    end else if (tb_we) mem[tb_addr] <= tb_data;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design produces them (R1 R2 R4 R5)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected write actual=%0h:%0h expected=none", mem_addr, mem_wdata);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        if (e.a !== mem_addr || e.d !== mem_wdata) begin
          errors++;
          $display("FAIL R2/R4/R5 write actual=%0h:%0h expected=%0h:%0h",
                   mem_addr, mem_wdata, e.a, e.d);
        end
      end
    end
  end

  task automatic preload();
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      shadow[a] = {a[3:0], 4'h9};
      tb_we = 1; tb_addr = AW'(a); tb_data = shadow[a];
    end
    @(negedge clk);
    tb_we = 0;
    @(negedge clk);
  endtask

  task automatic run(input string req, input logic keep, input int stop,
                     input logic exp_fail, input bit disturb);
    int cyc;
    for (int a = 0; a <= stop; a++) begin
      exp_q.push_back({AW'(a), 8'h55});
      exp_q.push_back({AW'(a), 8'hAA});
      exp_q.push_back({AW'(a), keep ? shadow[a] : 8'h00});
    end
    @(negedge clk);
    start_i = 1; keep_i = keep;
    @(negedge clk);
    start_i = 0;
    cyc = 1;
    while (!done_o && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 20) begin start_i = 1; keep_i = ~keep; end
      if (disturb && cyc == 21) start_i = 0;
    end
    check({req, " R7 cycles to done"}, cyc, 6 * (stop + 1) + 1);
    check({req, " R6/R7 fail flag"}, fail_o, exp_fail);
    check({req, " R1 all writes seen"}, exp_q.size(), 0);
    exp_q.delete();
    for (int a = 0; a < N; a++) begin
      logic [DW-1:0] want;
      want = (a <= stop) ? (keep ? shadow[a] : 8'h00) : shadow[a];
      check({req, (a <= stop) ? (keep ? " R5 kept word" : " R4 cleared word")
                              : " R6 untouched word"}, mem[a], want);
    end
    repeat (3) @(negedge clk);
    check({req, " R9 done holds"}, done_o, 1'b1);
    check({req, " R6 no write after done"}, mem_we, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; keep_i = 0; tb_we = 0; tb_addr = '0; tb_data = '0;
    f_on = 0; f_addr = '0; f_mask = '0; f_val = '0;
    repeat (3) @(negedge clk);
    check("R8 done in reset", done_o, 0);
    check("R8 fail in reset", fail_o, 0);
    check("R8 we in reset", mem_we, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R8 done after reset", done_o, 0);
    check("R8 we after reset", mem_we, 0);

    preload();
    run("preserve", 1'b1, N - 1, 1'b0, 1'b0);

    preload();
    run("clear+R10 mode flip+R9 start ignored", 1'b0, N - 1, 1'b0, 1'b1);

    preload();
    f_on = 1; f_addr = 4'd5; f_mask = 8'h01; f_val = 8'h01;
    run("R6 fault on complement", 1'b1, 5, 1'b1, 1'b0);

    preload();
    f_addr = 4'd0; f_mask = 8'h01; f_val = 8'h00;
    run("R6 fault on first pattern", 1'b0, 0, 1'b1, 1'b0);

    f_on = 0;
    preload();
    run("R9 restart clears fail", 1'b1, N - 1, 1'b0, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule